// File: doc/BRIEF.md
# Pin Request Servicing with End-of-Interrupt Release

This block sits between a set of interrupt input pins and the delivery logic of an interrupt routing controller. Each pin has a programmed entry supplied by an external register block: an interrupt vector, a mask bit, a trigger mode (edge or level) and a polarity bit. Pin activity arrives as indexed events carrying the pin's raw level. The block turns that activity into a pending-request bit per pin. It then decides whether the pin needs service and issues delivery requests, one at a time, on a valid/ready handshake. Each request carries the vector and the pin index. A delivered or failed result comes back for each request.

Level-triggered pins carry a remote-pending flag. After a successful delivery the flag is set, and it blocks repeat deliveries until an end-of-interrupt (EOI) message arrives with a matching vector. The EOI is compared against every pin's programmed vector. Each matching pin raises a one-cycle acknowledge bit. A level-type EOI also releases the remote-pending flag of every matching pin, and re-services a matching pin that is unmasked and whose request is still pending. Resolving which processor receives a delivery is left to the consumer of the request port.

Top module: `pin_service_eoi`

## Requirements
- R1: After reset no request is presented (`req_valid` low) and `ack_pins` is all zeros.
- R2: A pin's effective level is its raw level XOR its polarity bit. A pin with polarity 1 asserts on a raw 0 and deasserts on a raw 1.
- R3: An asserting event on an unmasked edge-triggered pin (`cfg_level` bit 0) issues exactly one delivery request with that pin's vector and index. A deasserting event issues none. The pin's request bit is cleared once its service completes, whatever the result.
- R4: Servicing a masked pin (`cfg_mask` bit 1) issues no delivery request.
- R5: A successful delivery (`res_ok`=1) of a level-triggered pin (`cfg_level` bit 1) sets its remote-pending flag. While the flag is set, further asserting events on that pin issue no request.
- R6: A failed delivery (`res_ok`=0) of a level pin leaves its remote-pending flag clear, so the next asserting event delivers again.
- R7: A level-type EOI (`eoi_level`=1) clears the remote-pending flag of every pin whose vector equals `eoi_vector`. It re-services each such pin that is unmasked and whose request bit is still set.
- R8: The cycle after any EOI, `ack_pins` bit i is 1 exactly for the pins whose programmed vector equals the EOI vector.
- R9: An edge-type EOI (`eoi_level`=0) only acknowledges. It changes no remote-pending flag and issues no request.
- R10: When several pins need service, they are taken in ascending index order, one outstanding request at a time.
- R11: Events whose `irq_index` is not below the pin count have no effect.
- R12: An asserting event and a level-type EOI that release the same pin in the same cycle service that pin exactly once.
- R13: Once `req_valid` is raised it stays high, with `req_vector` and `req_pin` unchanged, until `req_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_vector | input | N_PINS*VEC_W | Programmed vector per pin, pin i at bits [i*VEC_W +: VEC_W] |
| cfg_mask | input | N_PINS | Mask bit per pin, 1 = masked |
| cfg_level | input | N_PINS | Trigger mode per pin, 1 = level, 0 = edge |
| cfg_polarity | input | N_PINS | Polarity per pin, 1 = active low |
| irq_valid | input | 1 | Pin event strobe |
| irq_index | input | IDX_W | Pin index of the event |
| irq_level | input | 1 | Raw pin level of the event |
| eoi_valid | input | 1 | EOI message strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| eoi_level | input | 1 | 1 = level-type EOI, 0 = edge-type |
| req_valid | output | 1 | Delivery request present |
| req_ready | input | 1 | Consumer accepts the request |
| req_vector | output | VEC_W | Vector of the request |
| req_pin | output | $clog2(N_PINS) | Pin index of the request |
| res_valid | input | 1 | Delivery result strobe, at least one cycle after acceptance |
| res_ok | input | 1 | 1 = delivered, 0 = failed |
| ack_pins | output | N_PINS | One-cycle acknowledge per matching pin after an EOI |

## Verification
An asserting event and a level-type EOI can land on the same pin in the same clock cycle. If both paths took their decisions from the registered state, the event would see the remote-pending flag still set and the EOI would see a request bit not yet set. The pin would then never be serviced. The bench raises a level pin's remote-pending flag and lowers its input, then issues that pin's assertion and the matching level EOI together. It requires exactly one delivery for that pin, followed by a re-service of a second pin that shares the vector and is still asserted, in ascending order, and no further request after that.

// File: rtl/pinsvc_pkg.sv
package pinsvc_pkg;

  typedef enum logic [1:0] {
    SVC_IDLE = 2'd0,
    SVC_REQ  = 2'd1,
    SVC_WAIT = 2'd2
  } svc_state_e;

  // Effective pin level after polarity inversion.
  function automatic logic eff_level(input logic raw, input logic active_low);
    return raw ^ active_low;
  endfunction

  // Decision taken when a pin's effective level is high.
  function automatic logic needs_service(input logic is_edge,
                                         input logic was_pending,
                                         input logic remote_busy);
    return (is_edge && !was_pending) || !remote_busy;
  endfunction

endpackage

// File: rtl/pinsvc_eoi_match.sv
module pinsvc_eoi_match #(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8
) (
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  input  logic [N_PINS*VEC_W-1:0] cfg_vector,
  output logic [N_PINS-1:0]       hit
);
  for (genvar g = 0; g < N_PINS; g++) begin : g_cmp
    assign hit[g] = eoi_valid && (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);
  end
endmodule

// File: rtl/pinsvc_sched.sv
module pinsvc_sched
  import pinsvc_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8,
  localparam int PIN_W = $clog2(N_PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PINS-1:0]       pend,
  input  logic [N_PINS*VEC_W-1:0] cfg_vector,
  input  logic [N_PINS-1:0]       cfg_mask,
  input  logic [N_PINS-1:0]       cfg_level,
  output logic [N_PINS-1:0]       pick_oh,
  output logic                    done_valid,
  output logic [N_PINS-1:0]       done_oh,
  output logic                    done_ok,
  output logic                    done_lvl,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [VEC_W-1:0]        req_vector,
  output logic [PIN_W-1:0]        req_pin,
  input  logic                    res_valid,
  input  logic                    res_ok
);
  svc_state_e        state;
  logic [PIN_W-1:0]  cur_idx;
  logic [VEC_W-1:0]  cur_vec;
  logic              cur_lvl;
  logic [PIN_W-1:0]  pick_idx;
  logic              any_pend;
  logic              go;
  logic              go_masked;

  always_comb begin
    pick_idx = '0;
    for (int i = N_PINS - 1; i >= 0; i--) begin
      if (pend[i]) pick_idx = PIN_W'(i);
    end
  end

  assign any_pend  = |pend;
  assign go        = (state == SVC_IDLE) && any_pend;
  assign go_masked = go && cfg_mask[pick_idx];

  always_comb begin
    pick_oh = '0;
    if (go) pick_oh[pick_idx] = 1'b1;
  end

  always_comb begin
    done_valid = 1'b0;
    done_oh    = '0;
    done_ok    = 1'b0;
    done_lvl   = 1'b0;
    if (go_masked) begin
      done_valid        = 1'b1;
      done_oh[pick_idx] = 1'b1;
      done_lvl          = cfg_level[pick_idx];
    end else if ((state == SVC_WAIT) && res_valid) begin
      done_valid       = 1'b1;
      done_oh[cur_idx] = 1'b1;
      done_ok          = res_ok;
      done_lvl         = cur_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SVC_IDLE;
      cur_idx <= '0;
      cur_vec <= '0;
      cur_lvl <= 1'b0;
    end else begin
      unique case (state)
        SVC_IDLE: if (go && !go_masked) begin
          state   <= SVC_REQ;
          cur_idx <= pick_idx;
          cur_vec <= cfg_vector[pick_idx*VEC_W +: VEC_W];
          cur_lvl <= cfg_level[pick_idx];
        end
        SVC_REQ:  if (req_ready) state <= SVC_WAIT;
        SVC_WAIT: if (res_valid) state <= SVC_IDLE;
        default:  state <= SVC_IDLE;
      endcase
    end
  end

  assign req_valid  = (state == SVC_REQ);
  assign req_vector = cur_vec;
  assign req_pin    = cur_idx;

  // R13: request held stable until accepted
  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_vector) && $stable(req_pin)));

  // R10: at most one pin taken per cycle
  p_single_pick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh));

  // R10: the taken pin has no lower-index pending neighbour
  p_lowest_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_oh != '0) |-> ((pend & (pick_oh - 1'b1)) == '0));

endmodule

// File: rtl/pin_service_eoi.sv
module pin_service_eoi
  import pinsvc_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter int VEC_W  = 8,
  parameter int IDX_W  = 4,
  localparam int PIN_W = $clog2(N_PINS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PINS*VEC_W-1:0] cfg_vector,
  input  logic [N_PINS-1:0]       cfg_mask,
  input  logic [N_PINS-1:0]       cfg_level,
  input  logic [N_PINS-1:0]       cfg_polarity,
  input  logic                    irq_valid,
  input  logic [IDX_W-1:0]        irq_index,
  input  logic                    irq_level,
  input  logic                    eoi_valid,
  input  logic [VEC_W-1:0]        eoi_vector,
  input  logic                    eoi_level,
  output logic                    req_valid,
  input  logic                    req_ready,
  output logic [VEC_W-1:0]        req_vector,
  output logic [PIN_W-1:0]        req_pin,
  input  logic                    res_valid,
  input  logic                    res_ok,
  output logic [N_PINS-1:0]       ack_pins
);
  logic [N_PINS-1:0] pending;
  logic [N_PINS-1:0] remote;
  logic [N_PINS-1:0] svc_pend;
  logic [N_PINS-1:0] pending_nxt;
  logic [N_PINS-1:0] remote_nxt;
  logic [N_PINS-1:0] svc_pend_nxt;

  // Named internal events
  logic              irq_in_range;
  logic [PIN_W-1:0]  irq_pin;
  logic              irq_eff;
  logic [N_PINS-1:0] evt_hit;
  logic [N_PINS-1:0] evt_service;
  logic [N_PINS-1:0] eoi_hit;
  logic [N_PINS-1:0] eoi_release;
  logic [N_PINS-1:0] eoi_service;
  logic [N_PINS-1:0] pick_oh;
  logic              done_valid;
  logic [N_PINS-1:0] done_oh;
  logic              done_ok;
  logic              done_lvl;

  assign irq_in_range = irq_valid && (irq_index < IDX_W'(N_PINS));
  assign irq_pin      = irq_index[PIN_W-1:0];
  assign irq_eff      = eff_level(irq_level, cfg_polarity[irq_pin]);

  pinsvc_eoi_match #(.N_PINS(N_PINS), .VEC_W(VEC_W)) u_match (
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .cfg_vector (cfg_vector),
    .hit        (eoi_hit)
  );

  pinsvc_sched #(.N_PINS(N_PINS), .VEC_W(VEC_W)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (svc_pend),
    .cfg_vector (cfg_vector),
    .cfg_mask   (cfg_mask),
    .cfg_level  (cfg_level),
    .pick_oh    (pick_oh),
    .done_valid (done_valid),
    .done_oh    (done_oh),
    .done_ok    (done_ok),
    .done_lvl   (done_lvl),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vector (req_vector),
    .req_pin    (req_pin),
    .res_valid  (res_valid),
    .res_ok     (res_ok)
  );

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    assign evt_hit[g]     = irq_in_range && (irq_pin == PIN_W'(g));
    assign evt_service[g] = evt_hit[g] && irq_eff &&
                            needs_service(!cfg_level[g], pending[g], remote[g]);
    assign eoi_release[g] = eoi_hit[g] && eoi_level;

    always_comb begin
      pending_nxt[g] = pending[g];
      if (done_valid && done_oh[g] && !done_lvl) pending_nxt[g] = 1'b0;
      if (evt_hit[g]) pending_nxt[g] = irq_eff;
    end

    always_comb begin
      remote_nxt[g] = remote[g];
      if (done_valid && done_oh[g] && done_ok && done_lvl) remote_nxt[g] = 1'b1;
      if (eoi_release[g]) remote_nxt[g] = 1'b0;
    end

    // Uses the next request bit so a same-cycle assertion is not lost.
    assign eoi_service[g] = eoi_release[g] && !cfg_mask[g] && pending_nxt[g];
  end

  assign svc_pend_nxt = (svc_pend & ~pick_oh) | evt_service | eoi_service;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      remote   <= '0;
      svc_pend <= '0;
      ack_pins <= '0;
    end else begin
      pending  <= pending_nxt;
      remote   <= remote_nxt;
      svc_pend <= svc_pend_nxt;
      ack_pins <= eoi_hit;
    end
  end

  // R8: acknowledge follows every EOI with the matching pins
  p_ack_follows_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_valid |=> (ack_pins == $past(eoi_hit)));

  // R7: a level EOI leaves no matching pin remote-pending
  p_eoi_clears_remote_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_level) |=> ((remote & $past(eoi_hit)) == '0));

  // R5: a delivered level pin becomes remote-pending
  p_remote_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_ok && done_lvl && !(eoi_valid && eoi_level)) |=>
      ((remote & $past(done_oh)) != '0));

  // R11: out-of-range events start no service
  p_oob_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_in_range && !eoi_valid) |=> ((svc_pend & ~$past(svc_pend)) == '0));

endmodule

// File: tb/pin_service_eoi_test.sv
`timescale 1ns/1ps
module pin_service_eoi_test;
  localparam int N = 8;
  localparam int VW = 8;
  localparam int IW = 4;
  localparam int PW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*VW-1:0] cfg_vector;
  logic [N-1:0] cfg_mask, cfg_level, cfg_polarity;
  logic irq_valid = 1'b0;
  logic [IW-1:0] irq_index = '0;
  logic irq_level = 1'b0;
  logic eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic eoi_level = 1'b0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [VW-1:0] req_vector;
  logic [PW-1:0] req_pin;
  logic res_valid = 1'b0;
  logic res_ok = 1'b0;
  logic [N-1:0] ack_pins;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int cur_req = 1;
  logic hold_ready = 1'b0;
  logic fail_mode = 1'b0;
  logic rsp_due = 1'b0;

  typedef struct packed {
    logic [PW-1:0] pin;
    logic [VW-1:0] vec;
    logic [7:0]    req;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  pin_service_eoi #(.N_PINS(N), .VEC_W(VW), .IDX_W(IW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_vector(cfg_vector), .cfg_mask(cfg_mask),
    .cfg_level(cfg_level), .cfg_polarity(cfg_polarity),
    .irq_valid(irq_valid), .irq_index(irq_index), .irq_level(irq_level),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .eoi_level(eoi_level),
    .req_valid(req_valid), .req_ready(req_ready), .req_vector(req_vector),
    .req_pin(req_pin), .res_valid(res_valid), .res_ok(res_ok), .ack_pins(ack_pins)
  );

  // Pin set-up: 0 edge 0x20, 1 edge active-low 0x21, 2/3 level 0x30,
  // 4 masked edge 0x40, 5 level active-low 0x35, 6/7 masked.
  initial begin
    cfg_vector = {8'h47, 8'h46, 8'h35, 8'h40, 8'h30, 8'h30, 8'h21, 8'h20};
    cfg_mask     = 8'b1101_0000;
    cfg_level    = 8'b0010_1100;
    cfg_polarity = 8'b0010_0010;
  end

  function automatic void report(input bit ok, input int req, input string what,
                                 input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, expv);
    end
  endfunction

  // Responder and monitor: the scoreboard pops an item on each accepted request.
  always @(negedge clk) begin
    cyc++;
    res_valid = 1'b0;
    if (rsp_due) begin
      res_valid = 1'b1;
      res_ok = !fail_mode;
      rsp_due = 1'b0;
    end
    req_ready = !hold_ready && ((cyc % 3) != 1);
    if (rst_n && req_valid && req_ready) begin
      rsp_due = 1'b1;
      if (exp_q.size() == 0) begin
        report(1'b0, cur_req, "unexpected request pin/vector",
               {req_pin, req_vector}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        report({req_pin, req_vector} == {e.pin, e.vec}, int'(e.req),
               "request pin/vector", {req_pin, req_vector}, {e.pin, e.vec});
      end
    end
  end

  // Watchdog
  always @(negedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R0 watchdog expired: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic expect_req(input int pin, input int vec, input int req);
    exp_t e;
    e.pin = PW'(pin);
    e.vec = VW'(vec);
    e.req = 8'(req);
    exp_q.push_back(e);
  endtask

  task automatic pin_evt(input int idx, input bit lvl);
    @(negedge clk);
    irq_valid = 1'b1; irq_index = IW'(idx); irq_level = lvl;
    @(negedge clk);
    irq_valid = 1'b0;
  endtask

  task automatic send_eoi(input int vec, input bit lvl, input int exp_ack, input int req);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = VW'(vec); eoi_level = lvl;
    @(negedge clk);
    eoi_valid = 1'b0;
    report(ack_pins == N'(exp_ack), req, "ack pins", ack_pins, exp_ack);
  endtask

  // Waits for every expected request, then an idle window for strays.
  task automatic drain(input int req);
    int waited = 0;
    while (exp_q.size() != 0 && waited < 300) begin
      @(negedge clk);
      waited++;
    end
    report(exp_q.size() == 0, req, "outstanding expected requests", exp_q.size(), 0);
    exp_q.delete();
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    report(req_valid == 1'b0, 1, "req_valid in reset", req_valid, 0);
    report(ack_pins == '0, 1, "ack_pins in reset", ack_pins, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    report(req_valid == 1'b0, 1, "req_valid after reset", req_valid, 0);

    // R3: edge pin, assert / deassert / assert
    cur_req = 3;
    expect_req(0, 8'h20, 3); pin_evt(0, 1'b1); drain(3);
    pin_evt(0, 1'b0); drain(3);
    expect_req(0, 8'h20, 3); pin_evt(0, 1'b1); drain(3);

    // R2: active-low edge pin asserts on raw 0 only
    cur_req = 2;
    expect_req(1, 8'h21, 2); pin_evt(1, 1'b0); drain(2);
    pin_evt(1, 1'b1); drain(2);

    // R4: masked pin never requests
    cur_req = 4;
    pin_evt(4, 1'b1); drain(4);

    // R5: level pin delivered, then blocked while remote-pending
    cur_req = 5;
    expect_req(2, 8'h30, 5); pin_evt(2, 1'b1); drain(5);
    pin_evt(2, 1'b1); drain(5);

    // R7 and R8: level EOI hits pins 2 and 3; pin 2 still asserted is re-serviced
    cur_req = 7;
    expect_req(2, 8'h30, 7);
    send_eoi(8'h30, 1'b1, 32'h0C, 8);
    drain(7);
    pin_evt(2, 1'b0);
    send_eoi(8'h30, 1'b1, 32'h0C, 8);
    drain(7);

    // R9: edge-type EOI only acknowledges; non-matching vector acks nothing
    cur_req = 9;
    send_eoi(8'h20, 1'b0, 32'h01, 9);
    send_eoi(8'h99, 1'b1, 32'h00, 8);
    drain(9);

    // R6: failed level delivery leaves the pin free to deliver again
    cur_req = 6;
    fail_mode = 1'b1;
    expect_req(5, 8'h35, 6); pin_evt(5, 1'b0); drain(6);
    fail_mode = 1'b0;
    expect_req(5, 8'h35, 6); pin_evt(5, 1'b0); drain(6);
    pin_evt(5, 1'b0); drain(6);

    // R10: stall pin 0, queue pins 3 and 1, expect ascending order (R13 stall)
    cur_req = 10;
    hold_ready = 1'b1;
    expect_req(0, 8'h20, 10);
    pin_evt(0, 1'b1);
    pin_evt(3, 1'b1);
    pin_evt(1, 1'b0);
    expect_req(1, 8'h21, 10);
    expect_req(3, 8'h30, 10);
    repeat (5) @(negedge clk);
    report(req_valid == 1'b1 && req_pin == '0, 13, "stalled request held",
           {req_valid, req_pin}, {1'b1, PW'(0)});
    hold_ready = 1'b0;
    drain(10);

    // R11: out-of-range indices that would alias pins 0 and 2
    cur_req = 11;
    pin_evt(8, 1'b1);
    pin_evt(10, 1'b1);
    drain(11);

    // R12: pin 2 remote-pending and low; assertion and level EOI in one cycle
    cur_req = 12;
    send_eoi(8'h30, 1'b1, 32'h0C, 8);  // clears remote of pin 3 and re-services it
    expect_req(3, 8'h30, 12);
    drain(12);
    expect_req(2, 8'h30, 12); pin_evt(2, 1'b1); drain(12);
    pin_evt(2, 1'b0);
    expect_req(2, 8'h30, 12);
    expect_req(3, 8'h30, 12);
    @(negedge clk);
    irq_valid = 1'b1; irq_index = IW'(2); irq_level = 1'b1;
    eoi_valid = 1'b1; eoi_vector = 8'h30; eoi_level = 1'b1;
    @(negedge clk);
    irq_valid = 1'b0; eoi_valid = 1'b0;
    report(ack_pins == 8'h0C, 12, "ack pins same-cycle", ack_pins, 8'h0C);
    drain(12);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule